// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block moves a processor subsystem between three operating modes (Run, Wait and Stop) and drives one clock enable each for the core, the memory and the peripherals. The CPU raises single-cycle wait or stop requests. Interrupt lines bring the subsystem back from Wait. A narrow set of wake events, or a reset, brings it back from Stop. The block drives only the enables. The clock gating cells, the PLL, the oscillator and the watchdog counter all sit outside it, and the watchdog clock is never gated here.

Software can veto each low-power instruction through two controls. One is a lock that stays set until reset once it has been written to 1. The other can be set and cleared freely. A vetoed request does nothing: the block stays in Run and raises a sticky flag. A Stop request made while the system clock select still points at the PLL is still honoured, because the PLL is never powered down by this block. It does raise a separate sticky error flag.

Top module: `lpm_clkctl`

## Requirements
- R1: After reset the mode output is Run (code 0), all three clock enables are 1, both sticky flags are 0 and all disable controls are clear.
- R2: In Run, an accepted `wait_req` moves the block to Wait (code 1) on the next edge. In Wait, `core_clk_en` and `mem_clk_en` are 0 and `per_clk_en` stays 1.
- R3: In Wait, any bit set in `irq_pend & irq_en` returns the block to Run on the next edge. Pending interrupts whose enable bit is 0 leave it in Wait.
- R4: In Run, an accepted `stop_req` moves the block to Stop (code 2), where all three enables are 0. If `stop_req` and `wait_req` arrive in the same cycle, Stop takes precedence.
- R5: Stop is left for Run only on `can_wake` or `async_irq`. In Stop, clocked interrupts, `wait_req` and `stop_req` have no effect. `wait_req` and `stop_req` are likewise ignored in Wait.
- R6: A cycle with `wdt_rst` high returns the block to Run from any mode. It also clears every disable control and both flags.
- R7: A request whose instruction is disabled, by either its lock or its free control, leaves the block in Run and sets `req_blocked`.
- R8: A write to address 0 sets the lock of Stop (data bit 0) and the lock of Wait (data bit 1) for each bit written as 1. Once a lock is set, later writes, including writes of 0, do not clear it.
- R9: A write to address 1 loads the free Stop disable from data bit 0 and the free Wait disable from data bit 1. These controls can be both set and cleared.
- R10: A write to address 2 clears `req_blocked` if data bit 0 is 1 and `clksel_err` if data bit 1 is 1. If a flag is set and cleared in the same cycle, the set wins.
- R11: An accepted `stop_req` while `clk_sel_osc` is 0 still enters Stop, and it sets `clksel_err`.
- R12: The three enables are registered and change on the same edge as the mode output. No other edge changes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on or external) |
| wdt_rst | input | 1 | Synchronous reset from the watchdog |
| wait_req | input | 1 | Wait instruction request pulse |
| stop_req | input | 1 | Stop instruction request pulse |
| irq_pend | input | N_IRQ | Pending clocked interrupt lines |
| irq_en | input | N_IRQ | Interrupt enables (1 = unmasked) |
| can_wake | input | 1 | CAN bus activity wake event |
| async_irq | input | 1 | Synchronized non-clocked interrupt |
| clk_sel_osc | input | 1 | 1 when the system clock is taken from the oscillator |
| wr_en | input | 1 | Control write strobe |
| wr_addr | input | ADDR_W | Control write address (0 lock, 1 free disable, 2 flag clear) |
| wr_data | input | 2 | Control write data (bit 0 Stop, bit 1 Wait) |
| core_clk_en | output | 1 | Core clock enable |
| mem_clk_en | output | 1 | Memory clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| mode | output | 2 | Current mode: 0 Run, 1 Wait, 2 Stop |
| req_blocked | output | 1 | Sticky flag: a request was suppressed |
| clksel_err | output | 1 | Sticky flag: Stop entered while the PLL was selected |

## Verification
The properties assume that every input is synchronous to `clk`, and that `async_irq` has already passed through a synchronizer outside the block. They also assume `wdt_rst` is a clean one-cycle level, so the next-cycle mode checks can exclude it. The stimulus changes every input only on the falling edge. It holds request and wake lines high for exactly one cycle, and it leaves `clk_sel_osc` steady except in the sequences that exercise the clock select error.

// File: rtl/lpm_pkg.sv
`timescale 1ns/1ps
package lpm_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_WAIT = 2'd1,
    MODE_STOP = 2'd2
  } lpm_mode_e;

  // Index of each low-power instruction in the control words
  localparam int unsigned IDX_STOP = 0;
  localparam int unsigned IDX_WAIT = 1;
  localparam int unsigned N_INSTR  = 2;

  // Control write addresses
  localparam int unsigned ADDR_LOCK = 0;
  localparam int unsigned ADDR_SOFT = 1;
  localparam int unsigned ADDR_CLR  = 2;

  // Flag-clear bit positions
  localparam int unsigned CLR_BLOCKED = 0;
  localparam int unsigned CLR_CLKERR  = 1;

  // Enable vector for a mode: {core, mem, per}
  function automatic logic [2:0] enables_for(lpm_mode_e m);
    logic [2:0] en;
    case (m)
      MODE_RUN:  en = 3'b111;
      MODE_WAIT: en = 3'b001;
      default:   en = 3'b000;
    endcase
    return en;
  endfunction

  // True when a sticky flag with a set and a clear input ends up set
  function automatic logic sticky_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

endpackage

// File: rtl/lpm_disable_regs.sv
`timescale 1ns/1ps
module lpm_disable_regs
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [N_INSTR-1:0] wr_data,
  output logic [N_INSTR-1:0] lock_q,
  output logic [N_INSTR-1:0] soft_q,
  output logic [N_INSTR-1:0] dis
);

  logic hit_lock;
  logic hit_soft;

  assign hit_lock = wr_en && (wr_addr == ADDR_W'(ADDR_LOCK));
  assign hit_soft = wr_en && (wr_addr == ADDR_W'(ADDR_SOFT));

  for (genvar i = 0; i < N_INSTR; i++) begin : g_instr
    // Write-once lock: only a 1 is taken, only reset clears it
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lock_q[i] <= 1'b0;
      end else if (wdt_rst) begin
        lock_q[i] <= 1'b0;
      end else if (hit_lock && wr_data[i]) begin
        lock_q[i] <= 1'b1;
      end
    end

    // Freely reprogrammable disable
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        soft_q[i] <= 1'b0;
      end else if (wdt_rst) begin
        soft_q[i] <= 1'b0;
      end else if (hit_soft) begin
        soft_q[i] <= wr_data[i];
      end
    end

    assign dis[i] = lock_q[i] | soft_q[i];
  end

endmodule

// File: rtl/lpm_mode_fsm.sv
`timescale 1ns/1ps
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned N_IRQ = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wdt_rst,
  input  logic             stop_req,
  input  logic             wait_req,
  input  logic             stop_dis,
  input  logic             wait_dis,
  input  logic [N_IRQ-1:0] irq_pend,
  input  logic [N_IRQ-1:0] irq_en,
  input  logic             can_wake,
  input  logic             async_irq,
  input  logic             clk_sel_osc,
  output lpm_mode_e        mode_q,
  output lpm_mode_e        mode_d,
  output logic             ev_blocked,
  output logic             ev_clk_err,
  output logic             ev_wake
);

  logic irq_hit;
  logic stop_wake;

  assign irq_hit   = |(irq_pend & irq_en);
  assign stop_wake = can_wake | async_irq;

  always_comb begin
    mode_d     = mode_q;
    ev_blocked = 1'b0;
    ev_clk_err = 1'b0;
    ev_wake    = 1'b0;
    if (wdt_rst) begin
      mode_d = MODE_RUN;
    end else begin
      case (mode_q)
        MODE_RUN: begin
          if (stop_req) begin
            if (stop_dis) begin
              ev_blocked = 1'b1;
            end else begin
              mode_d     = MODE_STOP;
              ev_clk_err = ~clk_sel_osc;
            end
          end else if (wait_req) begin
            if (wait_dis) begin
              ev_blocked = 1'b1;
            end else begin
              mode_d = MODE_WAIT;
            end
          end
        end
        MODE_WAIT: begin
          if (irq_hit) begin
            mode_d  = MODE_RUN;
            ev_wake = 1'b1;
          end
        end
        MODE_STOP: begin
          if (stop_wake) begin
            mode_d  = MODE_RUN;
            ev_wake = 1'b1;
          end
        end
        default: mode_d = MODE_RUN;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RUN;
    end else begin
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/lpm_clk_en.sv
`timescale 1ns/1ps
module lpm_clk_en
  import lpm_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  lpm_mode_e mode_d,
  output logic      core_en,
  output logic      mem_en,
  output logic      per_en
);

  logic [2:0] en_q;

  // Loaded from the next mode, so each enable flips on the mode edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 3'b111;
    end else begin
      en_q <= enables_for(mode_d);
    end
  end

  assign core_en = en_q[2];
  assign mem_en  = en_q[1];
  assign per_en  = en_q[0];

endmodule

// File: rtl/lpm_status.sv
`timescale 1ns/1ps
module lpm_status
  import lpm_pkg::*;
#(
  parameter int unsigned ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               set_blocked,
  input  logic               set_clk_err,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [N_INSTR-1:0] wr_data,
  output logic               blocked_q,
  output logic               clk_err_q
);

  logic hit_clr;
  logic clr_blocked;
  logic clr_clk_err;

  assign hit_clr     = wr_en && (wr_addr == ADDR_W'(ADDR_CLR));
  assign clr_blocked = hit_clr && wr_data[CLR_BLOCKED];
  assign clr_clk_err = hit_clr && wr_data[CLR_CLKERR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blocked_q <= 1'b0;
      clk_err_q <= 1'b0;
    end else if (wdt_rst) begin
      blocked_q <= 1'b0;
      clk_err_q <= 1'b0;
    end else begin
      blocked_q <= sticky_next(blocked_q, set_blocked, clr_blocked);
      clk_err_q <= sticky_next(clk_err_q, set_clk_err, clr_clk_err);
    end
  end

endmodule

// File: rtl/lpm_clkctl.sv
`timescale 1ns/1ps
module lpm_clkctl
  import lpm_pkg::*;
#(
  parameter int unsigned N_IRQ  = 8,
  parameter int unsigned ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wdt_rst,
  input  logic               wait_req,
  input  logic               stop_req,
  input  logic [N_IRQ-1:0]   irq_pend,
  input  logic [N_IRQ-1:0]   irq_en,
  input  logic               can_wake,
  input  logic               async_irq,
  input  logic               clk_sel_osc,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [N_INSTR-1:0] wr_data,
  output logic               core_clk_en,
  output logic               mem_clk_en,
  output logic               per_clk_en,
  output logic [1:0]         mode,
  output logic               req_blocked,
  output logic               clksel_err
);

  // Internal events brought out for the checker
  logic [N_INSTR-1:0] lock_w;
  logic [N_INSTR-1:0] soft_w;
  logic [N_INSTR-1:0] dis_w;
  lpm_mode_e          mode_q_w;
  lpm_mode_e          mode_d_w;
  logic               ev_blocked_w;
  logic               ev_clk_err_w;
  logic               ev_wake_w;

  lpm_disable_regs #(.ADDR_W(ADDR_W)) u_dis (
    .clk     (clk),
    .rst_n   (rst_n),
    .wdt_rst (wdt_rst),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .lock_q  (lock_w),
    .soft_q  (soft_w),
    .dis     (dis_w)
  );

  lpm_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_rst     (wdt_rst),
    .stop_req    (stop_req),
    .wait_req    (wait_req),
    .stop_dis    (dis_w[IDX_STOP]),
    .wait_dis    (dis_w[IDX_WAIT]),
    .irq_pend    (irq_pend),
    .irq_en      (irq_en),
    .can_wake    (can_wake),
    .async_irq   (async_irq),
    .clk_sel_osc (clk_sel_osc),
    .mode_q      (mode_q_w),
    .mode_d      (mode_d_w),
    .ev_blocked  (ev_blocked_w),
    .ev_clk_err  (ev_clk_err_w),
    .ev_wake     (ev_wake_w)
  );

  lpm_clk_en u_en (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode_d  (mode_d_w),
    .core_en (core_clk_en),
    .mem_en  (mem_clk_en),
    .per_en  (per_clk_en)
  );

  lpm_status #(.ADDR_W(ADDR_W)) u_stat (
    .clk         (clk),
    .rst_n       (rst_n),
    .wdt_rst     (wdt_rst),
    .set_blocked (ev_blocked_w),
    .set_clk_err (ev_clk_err_w),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .blocked_q   (req_blocked),
    .clk_err_q   (clksel_err)
  );

  assign mode = mode_q_w;

endmodule

// File: rtl/lpm_clkctl_chk.sv
`timescale 1ns/1ps
module lpm_clkctl_chk #(
  parameter int unsigned N_IRQ = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wdt_rst,
  input logic             stop_req,
  input logic [N_IRQ-1:0] irq_pend,
  input logic [N_IRQ-1:0] irq_en,
  input logic             can_wake,
  input logic             async_irq,
  input logic             clk_sel_osc,
  input logic             core_clk_en,
  input logic             mem_clk_en,
  input logic             per_clk_en,
  input logic [1:0]       mode,
  input logic             req_blocked,
  input logic             clksel_err,
  input logic [1:0]       lock_q,
  input logic             stop_dis,
  input logic             ev_wake
);

  // R1
  run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0) |-> (core_clk_en && mem_clk_en && per_clk_en));

  // R2
  wait_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1) |-> (!core_clk_en && !mem_clk_en && per_clk_en));

  // R4
  stop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2) |-> (!core_clk_en && !mem_clk_en && !per_clk_en));

  // R3
  wait_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd1 && |(irq_pend & irq_en) && !wdt_rst) |=> (mode == 2'd0));

  // R5
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && !can_wake && !async_irq && !wdt_rst) |=> (mode == 2'd2));

  // R5
  stop_wake_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd2 && ev_wake) |-> (can_wake || async_irq));

  // R6
  wdt_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdt_rst |=> (mode == 2'd0 && lock_q == 2'b00 && !req_blocked && !clksel_err));

  // R7
  blocked_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && stop_req && stop_dis && !wdt_rst) |=> (mode == 2'd0 && req_blocked));

  // R8
  lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wdt_rst |=> ((lock_q & $past(lock_q)) == $past(lock_q)));

  // R11
  clk_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'd0 && stop_req && !stop_dis && !clk_sel_osc && !wdt_rst)
      |=> (mode == 2'd2 && clksel_err));

  // R12
  en_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(mode) |-> ($stable(core_clk_en) && $stable(per_clk_en)));

  // R1
  mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3);

endmodule

bind lpm_clkctl lpm_clkctl_chk #(.N_IRQ(N_IRQ)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .wdt_rst     (wdt_rst),
  .stop_req    (stop_req),
  .irq_pend    (irq_pend),
  .irq_en      (irq_en),
  .can_wake    (can_wake),
  .async_irq   (async_irq),
  .clk_sel_osc (clk_sel_osc),
  .core_clk_en (core_clk_en),
  .mem_clk_en  (mem_clk_en),
  .per_clk_en  (per_clk_en),
  .mode        (mode),
  .req_blocked (req_blocked),
  .clksel_err  (clksel_err),
  .lock_q      (lock_w),
  .stop_dis    (dis_w[0]),
  .ev_wake     (ev_wake_w)
);

// File: tb/lpm_clkctl_tb_top.sv
`timescale 1ns/1ps
module lpm_clkctl_tb_top;

  localparam int N_IRQ = 8;
  localparam int MAX_CYC = 200000;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wdt_rst = 1'b0;
  logic             wait_req = 1'b0;
  logic             stop_req = 1'b0;
  logic [N_IRQ-1:0] irq_pend = '0;
  logic [N_IRQ-1:0] irq_en = '0;
  logic             can_wake = 1'b0;
  logic             async_irq = 1'b0;
  logic             clk_sel_osc = 1'b1;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_addr = '0;
  logic [1:0]       wr_data = '0;
  logic             core_clk_en, mem_clk_en, per_clk_en;
  logic [1:0]       mode;
  logic             req_blocked, clksel_err;

  always #2.5 clk = ~clk;

  lpm_clkctl #(.N_IRQ(N_IRQ), .ADDR_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .wdt_rst(wdt_rst), .wait_req(wait_req),
    .stop_req(stop_req), .irq_pend(irq_pend), .irq_en(irq_en),
    .can_wake(can_wake), .async_irq(async_irq), .clk_sel_osc(clk_sel_osc),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_clk_en(core_clk_en), .mem_clk_en(mem_clk_en), .per_clk_en(per_clk_en),
    .mode(mode), .req_blocked(req_blocked), .clksel_err(clksel_err)
  );

  typedef struct {
    logic             stp, wt, cw, ai, osc, wdt, wen;
    logic [N_IRQ-1:0] ip, ie;
    logic [1:0]       wa, wd;
  } stim_t;

  typedef struct {
    logic [1:0] md;
    logic       core, mem, per, blk, err;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_errors = 0;
  bit   done = 1'b0;

  // Reference model state, kept from the requirements
  int       m_mode = 0;
  bit [1:0] m_lock = '0;
  bit [1:0] m_soft = '0;
  bit       m_blk = 1'b0;
  bit       m_err = 1'b0;

  function automatic stim_t idle();
    stim_t s;
    s.stp = 0; s.wt = 0; s.cw = 0; s.ai = 0; s.osc = 1; s.wdt = 0; s.wen = 0;
    s.ip = '0; s.ie = '0; s.wa = '0; s.wd = '0;
    return s;
  endfunction

  task automatic compare(input exp_t e);
    logic [5:0] act, ex;
    act = {mode, core_clk_en, mem_clk_en, per_clk_en, 1'b0} | {5'b0, 1'b0};
    ex  = {e.md, e.core, e.mem, e.per, 1'b0};
    n_checks++;
    if (act != ex || req_blocked != e.blk || clksel_err != e.err) begin
      n_errors++;
      $display("FAIL %s: mode/core/mem/per/blk/err act=%0d/%0b/%0b/%0b/%0b/%0b exp=%0d/%0b/%0b/%0b/%0b/%0b",
               e.tag, mode, core_clk_en, mem_clk_en, per_clk_en, req_blocked, clksel_err,
               e.md, e.core, e.mem, e.per, e.blk, e.err);
    end
  endtask

  // Driver: apply stimulus, advance the model, queue the expectation
  task automatic tick(input stim_t s, input string tag);
    exp_t e;
    int   nm;
    bit   bset, eset;
    @(negedge clk);
    stop_req = s.stp; wait_req = s.wt; can_wake = s.cw; async_irq = s.ai;
    clk_sel_osc = s.osc; wdt_rst = s.wdt; irq_pend = s.ip; irq_en = s.ie;
    wr_en = s.wen; wr_addr = s.wa; wr_data = s.wd;
    nm = m_mode; bset = 0; eset = 0;
    if (s.wdt) begin
      nm = 0; m_lock = '0; m_soft = '0; m_blk = 0; m_err = 0;
    end else begin
      if (m_mode == 0) begin
        if (s.stp) begin
          if (m_lock[0] || m_soft[0]) bset = 1;
          else begin nm = 2; eset = !s.osc; end
        end else if (s.wt) begin
          if (m_lock[1] || m_soft[1]) bset = 1;
          else nm = 1;
        end
      end else if (m_mode == 1) begin
        if ((s.ip & s.ie) != 0) nm = 0;
      end else begin
        if (s.cw || s.ai) nm = 0;
      end
      m_blk = bset || (m_blk && !(s.wen && s.wa == 2 && s.wd[0]));
      m_err = eset || (m_err && !(s.wen && s.wa == 2 && s.wd[1]));
      if (s.wen && s.wa == 0) m_lock = m_lock | s.wd;
      if (s.wen && s.wa == 1) m_soft = s.wd;
    end
    m_mode = nm;
    e.md = 2'(nm); e.core = (nm == 0); e.mem = (nm == 0); e.per = (nm != 2);
    e.blk = m_blk; e.err = m_err; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: pop one expectation per edge, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front());
    end
  end

  // Watchdog
  initial begin
    for (int c = 0; c < MAX_CYC; c++) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    stim_t s;
    exp_t  r;
    repeat (3) @(posedge clk);
    @(negedge clk);
    r.md = 0; r.core = 1; r.mem = 1; r.per = 1; r.blk = 0; r.err = 0; r.tag = "R1 reset state";
    compare(r);
    rst_n = 1'b1;

    s = idle(); tick(s, "R1 idle after reset");
    // Wait entry and exit
    s = idle(); s.wt = 1; tick(s, "R2 wait entry");
    s = idle(); s.ip = 8'h04; tick(s, "R3 masked irq ignored");
    s = idle(); s.stp = 1; tick(s, "R5 stop_req ignored in wait");
    s = idle(); s.ip = 8'h04; s.ie = 8'h04; tick(s, "R3 unmasked irq exit");
    s = idle(); tick(s, "R3 back in run");
    // Stop entry and exits
    s = idle(); s.stp = 1; s.wt = 1; tick(s, "R4 stop over wait");
    s = idle(); s.ip = 8'hFF; s.ie = 8'hFF; tick(s, "R5 clocked irq ignored in stop");
    s = idle(); s.wt = 1; tick(s, "R5 wait_req ignored in stop");
    s = idle(); s.cw = 1; tick(s, "R5 can wake exit");
    s = idle(); s.stp = 1; tick(s, "R4 stop entry");
    s = idle(); tick(s, "R12 enables steady in stop");
    s = idle(); s.ai = 1; tick(s, "R5 async irq exit");
    // Free disable
    s = idle(); s.wen = 1; s.wa = 1; s.wd = 2'b01; tick(s, "R9 set free stop disable");
    s = idle(); s.stp = 1; tick(s, "R7 stop blocked by free disable");
    s = idle(); s.wen = 1; s.wa = 2; s.wd = 2'b01; tick(s, "R10 clear blocked flag");
    s = idle(); s.wen = 1; s.wa = 1; s.wd = 2'b00; tick(s, "R9 clear free disable");
    s = idle(); s.stp = 1; tick(s, "R9 stop allowed again");
    s = idle(); s.cw = 1; tick(s, "R5 exit");
    // Lock
    s = idle(); s.wen = 1; s.wa = 0; s.wd = 2'b10; tick(s, "R8 set wait lock");
    s = idle(); s.wen = 1; s.wa = 0; s.wd = 2'b00; tick(s, "R8 write 0 to lock");
    s = idle(); s.wen = 1; s.wa = 1; s.wd = 2'b00; tick(s, "R8 free clear leaves lock");
    s = idle(); s.wt = 1; tick(s, "R8 wait blocked by lock");
    s = idle(); s.wt = 1; s.wen = 1; s.wa = 2; s.wd = 2'b01; tick(s, "R10 set wins over clear");
    s = idle(); s.stp = 1; tick(s, "R7 stop still allowed with wait lock");
    s = idle(); s.ai = 1; tick(s, "R5 exit");
    // Clock select error
    s = idle(); s.osc = 0; s.stp = 1; tick(s, "R11 stop on PLL clock");
    s = idle(); s.osc = 0; s.wen = 1; s.wa = 2; s.wd = 2'b10; tick(s, "R10 clear clk error in stop");
    s = idle(); s.osc = 0; s.cw = 1; tick(s, "R5 exit");
    s = idle(); s.osc = 0; s.stp = 1; s.wen = 1; s.wa = 2; s.wd = 2'b10; tick(s, "R10 err set wins");
    // Watchdog reset from stop
    s = idle(); s.wdt = 1; tick(s, "R6 wdt reset from stop");
    s = idle(); s.wt = 1; tick(s, "R6 lock cleared, wait accepted");
    s = idle(); s.wdt = 1; tick(s, "R6 wdt reset from wait");
    s = idle(); tick(s, "R1 final idle");
    s = idle(); tick(s, "R1 drain");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

endmodule